// File: doc/BRIEF.md
# Interrupt Controller with Claim/Complete

This block gathers level-sensitive interrupt lines from up to 80 sources into one external-interrupt request for a single processor hart. Each source has a latched pending bit, an enable bit and a 3-bit priority. A global 2-bit threshold filters out low-priority requests. The request output is high whenever at least one source is pending, enabled and strictly above the threshold.

Software services interrupts through one claim/complete register. A read returns the ID of the best eligible source: highest priority first, lowest ID among equals. The same read moves that source from pending into service. While a source is in service, new assertions of its input are discarded. Writing the ID back to the same register ends the service, and a still-high level then re-pends on the next clock edge. ID 0 is reserved and means "nothing to service". The last claimed ID is also driven out on a status port until it is completed.

All configuration uses a 32-bit word-addressed bus inside a 1 KiB window. Reads are combinational while the read strobe is high. Every state change, including the side effect of a claim read, takes place on the next rising clock edge.

Top module: `plic_ctrl`

## Requirements
- R1: A synchronous active-high reset clears every priority, enable, pending and in-service bit, the threshold and the held claim ID. After reset, `ext_irq` is low, `active_id` is 0 and every register reads 0.
- R2: The priority of source n (1..79) is the word at byte offset 0x018 + 4*(n-1). It keeps only bits [2:0] of a write. The word at 0x154 has no source behind it: it reads 0 and ignores writes.
- R3: The enable words are at 0x200, 0x204 and 0x208. Bit b of word w enables source 32*w + b. Bit 0 of word 0 (ID 0) and bits 16..31 of word 2 (IDs 80..95) always read 0 and ignore writes.
- R4: The threshold is at 0x20C and keeps only bits [1:0] of a write.
- R5: The pending words at 0x000..0x008 are read-only, and writes to them change nothing. The three words at 0x00C..0x014 and any unmapped offset read 0 and ignore writes.
- R6: A source's pending bit is set at a rising edge where its input is high and the source is not in service. Bit b of pending word w is source 32*w + b. The bit stays set after the input falls, until the source is claimed.
- R7: A source is eligible when it is pending, enabled and its priority is strictly greater than the threshold. `ext_irq` is high exactly when an eligible source exists.
- R8: Among eligible sources, the winner has the highest priority, and on a tie the lowest ID wins. A read of the claim register at 0x210 returns the winner's ID in bits [6:0], with upper bits 0.
- R9: A claim read that returns a winner clears that source's pending bit and puts it in service. While it is in service, its input cannot set its pending bit.
- R10: A claim read with no eligible source returns 0 and changes no pending bit, in-service bit or held ID.
- R11: A write of value v to 0x210 takes source v out of service only if v exactly equals its ID. If the input is still high, the source becomes pending again at the next edge. A write naming a source that is not in service has no effect.
- R12: `active_id` takes the ID returned by a successful claim read. It returns to 0 when a completion write carries that same value, and it is unchanged by a completion of any other value.
- R13: `bus_rdata` shows the addressed register while `bus_re` is high and `bus_we` is low, and is 0 otherwise. Side effects occur on the clock edge that ends the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| irq_src | input | 80 | Level interrupt inputs; bit n is source n, bit 0 is unused |
| bus_addr | input | 10 | Byte address in the register window; bits [1:0] ignored |
| bus_we | input | 1 | Write strobe for one word |
| bus_re | input | 1 | Read strobe for one word; a claim read has a side effect |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| ext_irq | output | 1 | External interrupt request to the hart |
| active_id | output | 7 | ID of the source currently held as claimed, 0 if none |

## Verification
The eligibility rule is swept over one source across all 32 pairs of priority and threshold. This separates a strict from a non-strict comparison and catches a truncated threshold. A second pattern raises all 79 sources at once with a spread of priorities and half of one enable word cleared. It then drains them by repeated claims, checked against an arithmetic argmax that tells the priority order, the lowest-ID tie-break and enable masking apart. A single-source claim, re-assert and complete sequence, including a wrong-ID completion and an empty claim, separates in-service blocking from the re-pending of a still-high level. Register sweeps with garbage upper bits expose any masking fault in the priority, threshold and enable words.

// File: rtl/plic_pkg.sv
package plic_pkg;

    // Default geometry of the controller
    localparam int NUM_SRC  = 80;
    localparam int PRIO_W   = 3;
    localparam int THR_W    = 2;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 10;
    localparam int IDX_W    = ADDR_W - 2;

    // Register layout expressed in 32-bit word numbers
    localparam int PEND_WORD  = 0;
    localparam int MODE_WORD  = 3;
    localparam int PRIO_WORD  = 6;
    localparam int EN_WORD    = 128;
    localparam int THR_WORD   = 131;
    localparam int CLAIM_WORD = 132;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PEND,
        SEL_MODE,
        SEL_PRIO,
        SEL_EN,
        SEL_THR,
        SEL_CLAIM
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e           sel;
        logic [IDX_W-1:0]   idx;
    } reg_dec_t;

    typedef struct packed {
        logic               wr;
        logic               rd;
        reg_dec_t           dec;
        logic [DATA_W-1:0]  data;
    } bus_req_t;

    // Map a word address onto a register group and an index inside it
    function automatic reg_dec_t decode_word(input logic [IDX_W-1:0] wa,
                                             input int nwords,
                                             input int nsrc);
        int w;
        reg_dec_t d;
        w = int'(wa);
        d.sel = SEL_NONE;
        d.idx = '0;
        if (w < PEND_WORD + nwords) begin
            d.sel = SEL_PEND;
            d.idx = IDX_W'(w - PEND_WORD);
        end else if (w >= MODE_WORD && w < MODE_WORD + nwords) begin
            d.sel = SEL_MODE;
            d.idx = IDX_W'(w - MODE_WORD);
        end else if (w >= PRIO_WORD && w < PRIO_WORD + nsrc) begin
            d.sel = SEL_PRIO;
            d.idx = IDX_W'(w - PRIO_WORD);
        end else if (w >= EN_WORD && w < EN_WORD + nwords) begin
            d.sel = SEL_EN;
            d.idx = IDX_W'(w - EN_WORD);
        end else if (w == THR_WORD) begin
            d.sel = SEL_THR;
        end else if (w == CLAIM_WORD) begin
            d.sel = SEL_CLAIM;
        end
        return d;
    endfunction

endpackage

// File: rtl/plic_cfg.sv
module plic_cfg import plic_pkg::*; #(
    parameter int NSRC   = NUM_SRC,
    parameter int PW     = PRIO_W,
    parameter int TW     = THR_W,
    parameter int NWORDS = (NSRC + 31) / 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  bus_req_t                req,
    output logic [NSRC-1:0][PW-1:0] prio,
    output logic [NWORDS*32-1:0]    en,
    output logic [TW-1:0]           thr
);

    localparam int EN_BITS = NWORDS * 32;

    // Bits that correspond to a real, non-reserved source
    logic [EN_BITS-1:0] valid_mask;

    for (genvar b = 0; b < EN_BITS; b++) begin : g_mask
        if (b > 0 && b < NSRC) begin : g_on
            assign valid_mask[b] = 1'b1;
        end else begin : g_off
            assign valid_mask[b] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prio <= '0;
            en   <= '0;
            thr  <= '0;
        end else if (req.wr) begin
            if (req.dec.sel == SEL_PRIO) begin
                for (int i = 1; i < NSRC; i++) begin
                    if (int'(req.dec.idx) == i - 1) begin
                        prio[i] <= req.data[PW-1:0];
                    end
                end
            end
            if (req.dec.sel == SEL_EN) begin
                for (int w = 0; w < NWORDS; w++) begin
                    if (int'(req.dec.idx) == w) begin
                        en[w*32 +: 32] <= req.data & valid_mask[w*32 +: 32];
                    end
                end
            end
            if (req.dec.sel == SEL_THR) begin
                thr <= req.data[TW-1:0];
            end
        end
    end

    AST_THR_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.dec.sel == SEL_THR) |=> thr == $past(req.data[TW-1:0])); // R4

    AST_EN_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.dec.sel == SEL_EN) |=> (en & ~valid_mask) == '0); // R3

    AST_SRC0_PRIO_ZERO: assert property (@(posedge clk) disable iff (rst)
        prio[0] == '0); // R2

endmodule

// File: rtl/plic_gateway.sv
module plic_gateway #(
    parameter int NSRC = plic_pkg::NUM_SRC,
    parameter int IW   = $clog2(NSRC)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src,
    input  logic            take_fire,
    input  logic [IW-1:0]   take_id,
    input  logic            done_fire,
    input  logic [31:0]     done_val,
    output logic [NSRC-1:0] pend,
    output logic [NSRC-1:0] in_service
);

    logic unused_src0;
    assign unused_src0 = src[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            pend       <= '0;
            in_service <= '0;
        end else begin
            pend[0]       <= 1'b0;
            in_service[0] <= 1'b0;
            for (int i = 1; i < NSRC; i++) begin
                if (take_fire && take_id == IW'(i)) begin
                    pend[i]       <= 1'b0;
                    in_service[i] <= 1'b1;
                end else begin
                    pend[i] <= pend[i] | (src[i] & ~in_service[i]);
                    if (done_fire && done_val == 32'(i)) begin
                        in_service[i] <= 1'b0;
                    end
                end
            end
        end
    end

    AST_SERVICE_BLOCKS_PEND: assert property (@(posedge clk) disable iff (rst)
        (pend & in_service) == '0); // R9

    AST_TAKE_MOVES_SOURCE: assert property (@(posedge clk) disable iff (rst)
        take_fire |=> in_service[$past(take_id)] && !pend[$past(take_id)]); // R9

    AST_PEND_HELD: assert property (@(posedge clk) disable iff (rst)
        !take_fire |=> (pend & $past(pend)) == $past(pend)); // R6

endmodule

// File: rtl/plic_arbiter.sv
module plic_arbiter #(
    parameter int NSRC = plic_pkg::NUM_SRC,
    parameter int PW   = plic_pkg::PRIO_W,
    parameter int TW   = plic_pkg::THR_W,
    parameter int IW   = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]         pend,
    input  logic [NSRC-1:0]         en,
    input  logic [NSRC-1:0][PW-1:0] prio,
    input  logic [TW-1:0]           thr,
    output logic [IW-1:0]           win_id,
    output logic                    win_valid
);

    logic [PW-1:0] best;

    // Scan from the top ID down; ">=" lets a lower ID take over a tie
    always_comb begin
        best      = '0;
        win_id    = '0;
        win_valid = 1'b0;
        for (int i = NSRC - 1; i >= 1; i--) begin
            if (pend[i] && en[i] && prio[i] > PW'(thr)
                && (!win_valid || prio[i] >= best)) begin
                win_valid = 1'b1;
                best      = prio[i];
                win_id    = IW'(i);
            end
        end
    end

endmodule

// File: rtl/plic_ctrl.sv
module plic_ctrl import plic_pkg::*; #(
    parameter int NSRC = NUM_SRC,
    parameter int PW   = PRIO_W,
    parameter int TW   = THR_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NSRC-1:0]         irq_src,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    bus_we,
    input  logic                    bus_re,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    output logic                    ext_irq,
    output logic [$clog2(NSRC)-1:0] active_id
);

    localparam int NWORDS = (NSRC + 31) / 32;
    localparam int IW     = $clog2(NSRC);

    bus_req_t               req;
    logic [NSRC-1:0][PW-1:0] prio;
    logic [NWORDS*32-1:0]   en;
    logic [TW-1:0]          thr;
    logic [NSRC-1:0]        pend;
    logic [NSRC-1:0]        in_service;
    logic [NWORDS*32-1:0]   pend_words;
    logic [IW-1:0]          win_id;
    logic                   win_valid;
    logic                   claim_fire;
    logic                   done_fire;
    logic                   unused_addr;

    assign unused_addr = ^bus_addr[1:0];

    always_comb begin
        req.wr   = bus_we;
        req.rd   = bus_re && !bus_we;
        req.dec  = decode_word(bus_addr[ADDR_W-1:2], NWORDS, NSRC);
        req.data = bus_wdata;
    end

    assign claim_fire = req.rd && req.dec.sel == SEL_CLAIM && win_valid;
    assign done_fire  = req.wr && req.dec.sel == SEL_CLAIM;

    plic_cfg #(.NSRC(NSRC), .PW(PW), .TW(TW), .NWORDS(NWORDS)) u_cfg (
        .clk  (clk),
        .rst  (rst),
        .req  (req),
        .prio (prio),
        .en   (en),
        .thr  (thr)
    );

    plic_gateway #(.NSRC(NSRC), .IW(IW)) u_gate (
        .clk        (clk),
        .rst        (rst),
        .src        (irq_src),
        .take_fire  (claim_fire),
        .take_id    (win_id),
        .done_fire  (done_fire),
        .done_val   (req.data),
        .pend       (pend),
        .in_service (in_service)
    );

    plic_arbiter #(.NSRC(NSRC), .PW(PW), .TW(TW), .IW(IW)) u_arb (
        .pend      (pend),
        .en        (en[NSRC-1:0]),
        .prio      (prio),
        .thr       (thr),
        .win_id    (win_id),
        .win_valid (win_valid)
    );

    assign ext_irq    = win_valid;
    assign pend_words = {{(NWORDS*32-NSRC){1'b0}}, pend};

    // Held claim ID
    always_ff @(posedge clk) begin
        if (rst) begin
            active_id <= '0;
        end else if (claim_fire) begin
            active_id <= win_id;
        end else if (done_fire && req.data == 32'(active_id)) begin
            active_id <= '0;
        end
    end

    // Read data path
    always_comb begin
        bus_rdata = '0;
        if (req.rd) begin
            unique case (req.dec.sel)
                SEL_PEND: begin
                    for (int w = 0; w < NWORDS; w++) begin
                        if (int'(req.dec.idx) == w) bus_rdata = pend_words[w*32 +: 32];
                    end
                end
                SEL_EN: begin
                    for (int w = 0; w < NWORDS; w++) begin
                        if (int'(req.dec.idx) == w) bus_rdata = en[w*32 +: 32];
                    end
                end
                SEL_PRIO: begin
                    for (int i = 1; i < NSRC; i++) begin
                        if (int'(req.dec.idx) == i - 1) bus_rdata = 32'(prio[i]);
                    end
                end
                SEL_THR:   bus_rdata = 32'(thr);
                SEL_CLAIM: bus_rdata = win_valid ? 32'(win_id) : '0;
                default:   bus_rdata = '0;
            endcase
        end
    end

    AST_EMPTY_CLAIM_ZERO: assert property (@(posedge clk) disable iff (rst)
        (req.rd && req.dec.sel == SEL_CLAIM && !ext_irq) |-> bus_rdata == '0); // R10

    AST_IRQ_HAS_WINNER: assert property (@(posedge clk) disable iff (rst)
        ext_irq |-> (pend[win_id] && en[win_id] && prio[win_id] > PW'(thr) && win_id != '0)); // R7

    AST_ACTIVE_TAKES_CLAIM: assert property (@(posedge clk) disable iff (rst)
        claim_fire |=> active_id == $past(win_id)); // R12

    AST_ACTIVE_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (done_fire && req.data == 32'(active_id)) |=> active_id == '0); // R12

    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !bus_re |-> bus_rdata == '0); // R13

endmodule

// File: tb/plic_ctrl_test.sv
module plic_ctrl_test;

    localparam int N = 80;
    localparam logic [9:0] A_PEND  = 10'h000;
    localparam logic [9:0] A_MODE  = 10'h00C;
    localparam logic [9:0] A_PRIO  = 10'h018;
    localparam logic [9:0] A_EN    = 10'h200;
    localparam logic [9:0] A_THR   = 10'h20C;
    localparam logic [9:0] A_CLAIM = 10'h210;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [N-1:0] irq = '0;
    logic [9:0]  addr = '0;
    logic        we = 1'b0;
    logic        re = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ext_irq;
    logic [6:0]  active_id;

    int checks = 0;
    int errors = 0;

    int prio_m [N];
    bit en_m   [N];
    bit pend_m [N];
    int thr_m  = 0;

    always #5 clk = ~clk;

    plic_ctrl uut (
        .clk       (clk),
        .rst       (rst),
        .irq_src   (irq),
        .bus_addr  (addr),
        .bus_we    (we),
        .bus_re    (re),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .ext_irq   (ext_irq),
        .active_id (active_id)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a; re = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        re = 1'b0;
    endtask

    task automatic drive_src(input logic [N-1:0] v);
        @(negedge clk);
        irq = v;
        @(negedge clk);
    endtask

    function automatic int exp_winner();
        int best = -1;
        int id = 0;
        for (int n = 1; n < N; n++) begin
            if (pend_m[n] && en_m[n] && prio_m[n] > thr_m && prio_m[n] > best) begin
                best = prio_m[n];
                id = n;
            end
        end
        return id;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete (all requirements)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] expw;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        #1;
        chk("R1 ext_irq after reset", 32'(ext_irq), 0);
        chk("R1 active_id after reset", 32'(active_id), 0);
        rd(A_THR, v);         chk("R1 threshold", v, 0);
        rd(A_CLAIM, v);       chk("R1 claim", v, 0);
        rd(A_PEND + 4, v);    chk("R1 pending word1", v, 0);
        rd(A_PRIO, v);        chk("R1 priority src1", v, 0);
        rd(A_EN + 8, v);      chk("R1 enable word2", v, 0);

        // R2: priority words keep three bits; the word past the last source reads zero
        for (int n = 1; n <= N; n++) begin
            wr(A_PRIO + 10'(4 * (n - 1)), {24'hA5A5A5, 8'(n)});
        end
        for (int n = 1; n <= N; n++) begin
            rd(A_PRIO + 10'(4 * (n - 1)), v);
            chk($sformatf("R2 priority src%0d", n), v, (n < N) ? 32'(n % 8) : 32'h0);
            if (n < N) prio_m[n] = n % 8;
        end

        // R3: enable words with reserved bits
        wr(A_EN,     32'hFFFF_FFFF);
        wr(A_EN + 4, 32'hFFFF_FFFF);
        wr(A_EN + 8, 32'hFFFF_FFFF);
        rd(A_EN,     v); chk("R3 enable word0", v, 32'hFFFF_FFFE);
        rd(A_EN + 4, v); chk("R3 enable word1", v, 32'hFFFF_FFFF);
        rd(A_EN + 8, v); chk("R3 enable word2", v, 32'h0000_FFFF);
        for (int n = 1; n < N; n++) en_m[n] = 1'b1;

        // R4: threshold masking; R13: no read data without a read strobe
        wr(A_THR, 32'hFFFF_FFFE); rd(A_THR, v); chk("R4 threshold 2", v, 2);
        wr(A_THR, 32'hFFFF_FFFF); rd(A_THR, v); chk("R4 threshold 3", v, 3);
        @(negedge clk); addr = A_THR; re = 1'b0;
        #1 chk("R13 rdata idle", rdata, 0);
        wr(A_THR, 0);

        // R5: read-only pending, inert mode words, unmapped offset
        for (int w = 0; w < 3; w++) begin
            wr(A_PEND + 10'(4 * w), 32'hFFFF_FFFF);
            rd(A_PEND + 10'(4 * w), v);
            chk($sformatf("R5 pending word%0d write ignored", w), v, 0);
            wr(A_MODE + 10'(4 * w), 32'hFFFF_FFFF);
            rd(A_MODE + 10'(4 * w), v);
            chk($sformatf("R5 mode word%0d", w), v, 0);
        end
        wr(10'h300, 32'h1234_5678);
        rd(10'h300, v); chk("R5 unmapped offset", v, 0);

        // R6: pending latches a pulse on source 5
        drive_src(N'(1) << 5);
        drive_src('0);
        rd(A_PEND, v); chk("R6 pending latched", v, 32'h20);
        wr(A_PEND, 32'h0);
        rd(A_PEND, v); chk("R5 pending write keeps bit", v, 32'h20);

        // R7: strict comparison over every priority/threshold pair
        for (int p = 0; p < 8; p++) begin
            for (int t = 0; t < 4; t++) begin
                wr(A_PRIO + 10'(4 * 4), 32'(p));
                wr(A_THR, 32'(t));
                #1 chk($sformatf("R7 eligibility p%0d t%0d", p, t), 32'(ext_irq), 32'(p > t));
            end
        end
        wr(A_PRIO + 10'(4 * 4), 7);
        wr(A_THR, 0);
        wr(A_EN, 0);
        #1 chk("R7 disabled source", 32'(ext_irq), 0);
        wr(A_EN, 32'hFFFF_FFFF);
        #1 chk("R7 re-enabled source", 32'(ext_irq), 1);

        // R8/R9: claim moves source 5 into service
        wr(A_PRIO + 10'(4 * 4), 1);
        rd(A_CLAIM, v); chk("R8 claim returns id", v, 5);
        #1 chk("R12 active after claim", 32'(active_id), 5);
        chk("R9 ext_irq after claim", 32'(ext_irq), 0);
        rd(A_PEND, v); chk("R9 pending cleared", v, 0);
        drive_src(N'(1) << 5);
        rd(A_PEND, v); chk("R9 assertion dropped in service", v, 0);

        // R10: empty claim
        rd(A_CLAIM, v); chk("R10 empty claim", v, 0);
        #1 chk("R10 active unchanged", 32'(active_id), 5);
        rd(A_PEND, v); chk("R10 pending unchanged", v, 0);

        // R11/R12: wrong then right completion
        wr(A_CLAIM, 6);
        #1 chk("R12 other completion keeps active", 32'(active_id), 5);
        rd(A_PEND, v); chk("R11 still blocked", v, 0);
        wr(A_CLAIM, 32'h0000_0105);
        #1 chk("R11 upper bits block completion", 32'(active_id), 5);
        wr(A_CLAIM, 5);
        #1 chk("R12 active cleared", 32'(active_id), 0);
        rd(A_PEND, v); chk("R11 level re-pends", v, 32'h20);
        #1 chk("R11 ext_irq after re-pend", 32'(ext_irq), 1);
        drive_src('0);
        rd(A_CLAIM, v); chk("R8 second claim", v, 5);
        wr(A_CLAIM, 5);

        // R8: drain all sources by repeated claims
        thr_m = 1;
        wr(A_THR, 1);
        for (int n = 1; n < N; n++) begin
            prio_m[n] = (n * 5 + 3) % 8;
            wr(A_PRIO + 10'(4 * (n - 1)), 32'(prio_m[n]));
        end
        wr(A_EN + 4, 32'h0000_FFFF);
        for (int n = 48; n < 64; n++) en_m[n] = 1'b0;
        drive_src({N{1'b1}});
        drive_src('0);
        for (int n = 1; n < N; n++) pend_m[n] = 1'b1;
        for (int k = 0; k < 100; k++) begin
            int e;
            e = exp_winner();
            #1 chk($sformatf("R7 ext_irq before claim %0d", k), 32'(ext_irq), 32'(e != 0));
            rd(A_CLAIM, v);
            chk($sformatf("R8 winner step %0d", k), v, 32'(e));
            if (e == 0) break;
            pend_m[e] = 1'b0;
            wr(A_CLAIM, 32'(e));
        end
        for (int w = 0; w < 3; w++) begin
            expw = '0;
            for (int b = 0; b < 32; b++) begin
                if (w * 32 + b < N && pend_m[w * 32 + b]) expw[b] = 1'b1;
            end
            rd(A_PEND + 10'(4 * w), v);
            chk($sformatf("R6 pending word%0d after drain", w), v, expw);
        end

        // R1: reset in mid-operation
        wr(A_THR, 2);
        wr(A_PRIO + 10'(4 * 8), 7);
        drive_src(N'(1) << 9);
        rd(A_CLAIM, v); chk("R8 claim before reset", v, 9);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1 chk("R1 active cleared by reset", 32'(active_id), 0);
        chk("R1 ext_irq cleared by reset", 32'(ext_irq), 0);
        rd(A_THR, v);      chk("R1 threshold cleared by reset", v, 0);
        rd(A_PRIO + 32, v); chk("R1 priority cleared by reset", v, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule